// File: doc/BRIEF.md
# RTC Interrupt Flag and Request Unit

This block gathers three timekeeping interrupt events (periodic tick, alarm match and update-ended) into a status byte. Each event has an enable bit in a control byte. It drives a single active-low interrupt request that is built to look like an open-drain pin: a drive value plus an output enable, and the request is never driven high. Software can work in two ways. It can poll the flag bits with every enable at zero, or it can enable one or more sources and wait for the request line.

Reading the status byte is a multi-cycle access, marked by `stat_rd` being high. During the read, the byte presented to the bus is frozen. Any events that arrive while the read is in progress are parked in a pending register. On the first cycle after the read ends, every flag that was read is cleared and the parked events are posted. The update-ended source only raises the request line when the clock is not being set (`set_mode` low). Its flag is still recorded while the clock is being set.

Top module: `rtc_irq_unit`

## Requirements
- R1: An event strobe high at a clock edge, outside a read, sets its flag whatever its enable is. Status byte layout: bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update-ended flag, bits 3..0 read 0.
- R2: The request is active exactly when at least one source has both its flag and its enable set. Control byte layout: bit 6 = periodic enable, bit 5 = alarm enable, bit 4 = update enable, bit 3 = square-wave enable, bit 7 mirrors `set_mode`, bits 2..0 read 0. It is written by `wr_en` with `wr_sel_stat`=0, from the same bits of `wr_data`.
- R3: Outside a read, status bit 7 (request flag) equals `irq_oe`.
- R4: Writing an enable to 1 while its flag is already set activates the request in the cycle after the write edge.
- R5: The update-ended source contributes to the request only while `set_mode` is 0. Its flag is set either way.
- R6: From the first clock edge with `stat_rd` high until the clearing edge, `stat_byte` holds the value sampled at the start of the read, even if enables change.
- R7: On the first edge with `stat_rd` low after a read, all flags and the request flag clear, and the request is released.
- R8: Events that arrive during a read, including in its last cycle, are held and set their flags at the clearing edge. An event that arrives at the clearing edge itself is also set.
- R9: A write with `wr_sel_stat`=1 changes neither the status byte nor the control byte.
- R10: A synchronous low on `rst_n` clears all enables, the square-wave enable, all flags, the pending events and the request.
- R11: `irq_oe`=1 implies `irq_n`=0. When no source requests, `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_periodic | input | 1 | Periodic tick event strobe |
| ev_alarm | input | 1 | Alarm match event strobe |
| ev_update | input | 1 | Update-ended event strobe |
| stat_rd | input | 1 | High for the cycles of a status byte read |
| wr_en | input | 1 | Register write strobe |
| wr_sel_stat | input | 1 | Write target: 1 = status byte (ignored), 0 = control byte |
| wr_data | input | 8 | Write data |
| set_mode | input | 1 | Clock-setting bit; blocks the update-ended request |
| stat_byte | output | 8 | Status byte: request flag and three event flags |
| ctl_byte | output | 8 | Control byte readback |
| irq_n | output | 1 | Interrupt drive value, low when active |
| irq_oe | output | 1 | Interrupt output enable; 1 only while requesting |

## Verification
The bench targets the read protocol edges. It pulses an event in the middle of a read, in the last read cycle, and on the clearing edge itself. A design that cleared flags as the read began, or that dropped events at the boundary, would lose those flags after the read. The bench changes the enables while a read is in progress. A byte that was not frozen would show a changed request flag. The bench also enables a source whose flag was set earlier, which must raise the request at once. It holds `set_mode` with the update flag enabled, where the request must stay released. Finally, it writes to the read-only status byte and resets in the middle of a read, where a leak would leave flags or pending events behind.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_SRC  = 3;

    // Source indices inside the event/flag vector; vector maps onto status[6:4]
    localparam int IDX_UPD  = 0;
    localparam int IDX_ALM  = 1;
    localparam int IDX_PER  = 2;

    localparam int FLAG_LSB = 4;
    localparam int REQ_BIT  = 7;
    localparam int CTL_LSB  = 3;
    localparam int CTL_W    = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic sqw_en;
    } ctl_t;

    function automatic logic [BYTE_W-1:0] pack_status(input logic req, input src_vec_t flg);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[REQ_BIT] = req;
        b[FLAG_LSB +: NUM_SRC] = flg;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctl(input logic setb, input ctl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[REQ_BIT] = setb;
        b[CTL_LSB +: CTL_W] = c;
        return b;
    endfunction

    function automatic src_vec_t ctl_enables(input ctl_t c);
        src_vec_t v;
        v[IDX_PER] = c.per_en;
        v[IDX_ALM] = c.alm_en;
        v[IDX_UPD] = c.upd_en;
        return v;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import rtc_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd_act,
    output logic [N-1:0] flags,
    output logic         rd_busy
);

    logic [N-1:0] pend;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_busy <= 1'b0;
        else        rd_busy <= rd_act;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else if (rd_act) begin
                pend[i]  <= pend[i] | ev[i];
            end else if (rd_busy) begin
                flags[i] <= pend[i] | ev[i];
                pend[i]  <= 1'b0;
            end else if (ev[i]) begin
                flags[i] <= 1'b1;
            end
        end

        assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !rd_act && !rd_busy) |=> flags[i]);

        assert_pending_posted_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_busy && !rd_act && pend[i]) |=> flags[i]);
    end

    assert_flags_hold_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> $stable(flags));

    assert_clear_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && !rd_act && pend == '0 && ev == '0) |=> (flags == '0));

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wbits,
    output ctl_t             ctl
);

    always_ff @(posedge clk) begin
        if (!rst_n)  ctl <= '0;
        else if (we) ctl <= ctl_t'(wbits);
    end

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ctl == ctl_t'($past(wbits))));

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
    import rtc_irq_pkg::*;
(
    input  src_vec_t flags,
    input  ctl_t     ctl,
    input  logic     set_mode,
    output src_vec_t src_req,
    output logic     req
);

    src_vec_t en;
    src_vec_t gate;

    always_comb begin
        en            = ctl_enables(ctl);
        gate          = '1;
        gate[IDX_UPD] = ~set_mode;
        src_req       = flags & en & gate;
        req           = |src_req;
    end

endmodule

// File: rtl/irq_status_view.sv
module irq_status_view
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              rd_busy,
    input  logic [BYTE_W-1:0] live,
    output logic [BYTE_W-1:0] view
);

    logic [BYTE_W-1:0] snap;

    always_ff @(posedge clk) begin
        if (!rst_n)                  snap <= '0;
        else if (rd_act && !rd_busy) snap <= live;
    end

    assign view = rd_busy ? snap : live;

    assert_view_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && $past(rd_busy)) |-> $stable(view));

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    input  logic              stat_rd,
    input  logic              wr_en,
    input  logic              wr_sel_stat,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              set_mode,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] ctl_byte,
    output logic              irq_n,
    output logic              irq_oe
);

    src_vec_t          ev;
    src_vec_t          flags;
    src_vec_t          src_req;
    ctl_t              ctl;
    logic              rd_busy;
    logic              req;
    logic              ctl_we;
    logic [BYTE_W-1:0] live_stat;
    logic              unused_wr_bits;

    always_comb begin
        ev          = '0;
        ev[IDX_PER] = ev_periodic;
        ev[IDX_ALM] = ev_alarm;
        ev[IDX_UPD] = ev_update;
    end

    assign ctl_we         = wr_en & ~wr_sel_stat;
    assign unused_wr_bits = ^{wr_data[BYTE_W-1:CTL_LSB+CTL_W], wr_data[CTL_LSB-1:0]};

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_act  (stat_rd),
        .flags   (flags),
        .rd_busy (rd_busy)
    );

    irq_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wbits (wr_data[CTL_LSB +: CTL_W]),
        .ctl   (ctl)
    );

    irq_req_merge u_merge (
        .flags    (flags),
        .ctl      (ctl),
        .set_mode (set_mode),
        .src_req  (src_req),
        .req      (req)
    );

    assign live_stat = pack_status(req, flags);

    irq_status_view u_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (stat_rd),
        .rd_busy (rd_busy),
        .live    (live_stat),
        .view    (stat_byte)
    );

    assign ctl_byte = pack_ctl(set_mode, ctl);
    assign irq_oe   = req;
    assign irq_n    = ~req;

    assert_never_drive_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> !irq_n);

    assert_req_flag_tracks_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> (stat_byte[REQ_BIT] == irq_oe));

    assert_update_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !(flags[IDX_PER] && ctl.per_en) && !(flags[IDX_ALM] && ctl.alm_en))
        |-> !irq_oe);

    assert_source_req_onehot_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0) |-> !irq_oe);

endmodule

// File: tb/sim_rtc_irq_unit.sv
module sim_rtc_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic       stat_rd = 1'b0, wr_en = 1'b0, wr_sel_stat = 1'b0, set_mode = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] stat_byte, ctl_byte;
    logic       irq_n, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .stat_rd(stat_rd), .wr_en(wr_en), .wr_sel_stat(wr_sel_stat),
        .wr_data(wr_data), .set_mode(set_mode),
        .stat_byte(stat_byte), .ctl_byte(ctl_byte),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic p, input logic a, input logic u);
        ev_periodic = p; ev_alarm = a; ev_update = u;
        step();
        ev_periodic = 0; ev_alarm = 0; ev_update = 0;
    endtask

    task automatic wr(input logic sel_stat, input logic [7:0] d);
        wr_en = 1; wr_sel_stat = sel_stat; wr_data = d;
        step();
        wr_en = 0; wr_sel_stat = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic full_read();
        stat_rd = 1; step(); stat_rd = 0; step();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 reset status", stat_byte, 8'h00);
        chk("R10 reset ctl", ctl_byte, 8'h00);
        chk("R11 reset oe", {7'b0, irq_oe}, 8'h00);
    endtask

    task automatic t_poll();
        pulse(1, 0, 0);
        chk("R1 periodic flag", stat_byte, 8'h40);
        pulse(0, 1, 0);
        pulse(0, 0, 1);
        chk("R1 all flags no enable", stat_byte, 8'h70);
        chk("R11 released when disabled", {6'b0, irq_oe, irq_n}, 8'h01);
        full_read();
        chk("R7 cleared after read", stat_byte, 8'h00);
    endtask

    task automatic t_enable();
        wr(0, 8'h20);
        chk("R2 ctl alarm enable", ctl_byte, 8'h20);
        pulse(1, 0, 0);
        chk("R2 wrong source no irq", {7'b0, irq_oe}, 8'h00);
        pulse(0, 1, 0);
        chk("R2 alarm irq oe", {6'b0, irq_oe, irq_n}, 8'h02);
        chk("R3 request flag set", stat_byte, 8'hE0);
        full_read();
        chk("R7 irq released", {6'b0, irq_oe, irq_n}, 8'h01);
        chk("R7 status clear", stat_byte, 8'h00);
        wr(0, 8'h00);
    endtask

    task automatic t_late_enable();
        pulse(1, 0, 0);
        chk("R4 flag before enable", stat_byte, 8'h40);
        wr(0, 8'h40);
        chk("R4 irq after enable", {7'b0, irq_oe}, 8'h01);
        chk("R3 request flag", stat_byte, 8'hC0);
        wr(0, 8'h00);
        chk("R2 disable releases", {7'b0, irq_oe}, 8'h00);
        full_read();
    endtask

    task automatic t_update_gate();
        set_mode = 1;
        wr(0, 8'h10);
        chk("R2 ctl set mirror", ctl_byte, 8'h90);
        pulse(0, 0, 1);
        chk("R5 flag while setting", stat_byte, 8'h10);
        chk("R5 no irq while setting", {7'b0, irq_oe}, 8'h00);
        set_mode = 0;
        step();
        chk("R5 irq after set clear", {7'b0, irq_oe}, 8'h01);
        chk("R5 status", stat_byte, 8'h90);
        full_read();
        wr(0, 8'h00);
    endtask

    task automatic t_freeze();
        wr(0, 8'h40);
        pulse(1, 1, 0);
        chk("R6 before read", stat_byte, 8'hE0);
        stat_rd = 1;
        step();
        chk("R6 read start", stat_byte, 8'hE0);
        wr_en = 1; wr_sel_stat = 0; wr_data = 8'h00;
        step();
        wr_en = 0;
        chk("R6 frozen after enable change", stat_byte, 8'hE0);
        step();
        chk("R6 still frozen", stat_byte, 8'hE0);
        stat_rd = 0;
        step();
        chk("R7 clear at end", stat_byte, 8'h00);
        wr(0, 8'h40);
        chk("R7 no irq after clear", {7'b0, irq_oe}, 8'h00);
        wr(0, 8'h00);
    endtask

    task automatic t_read_events();
        stat_rd = 1;
        step();
        pulse(1, 0, 0);
        chk("R8 mid-read hidden", stat_byte, 8'h00);
        step();
        ev_alarm = 1;
        step();
        ev_alarm = 0;
        stat_rd = 0; ev_update = 1;
        step();
        ev_update = 0;
        chk("R8 posted after read", stat_byte, 8'h70);
        full_read();
        chk("R8 clean", stat_byte, 8'h00);
    endtask

    task automatic t_stat_write();
        wr(0, 8'h28);
        wr(1, 8'hFF);
        chk("R9 status unchanged", stat_byte, 8'h00);
        chk("R9 ctl unchanged", ctl_byte, 8'h28);
        pulse(0, 1, 0);
        wr(1, 8'h00);
        chk("R9 flags kept", stat_byte, 8'hA0);
        full_read();
    endtask

    task automatic t_reset_clear();
        wr(0, 8'hFF);
        chk("R2 ctl full write", ctl_byte, 8'h78);
        pulse(1, 1, 1);
        stat_rd = 1;
        step();
        pulse(1, 0, 0);
        rst_n = 0;
        step();
        stat_rd = 0;
        step();
        rst_n = 1;
        step();
        chk("R10 flags pending cleared", stat_byte, 8'h00);
        chk("R10 ctl cleared", ctl_byte, 8'h00);
        chk("R10 irq released", {6'b0, irq_oe, irq_n}, 8'h01);
    endtask

    initial begin
        t_reset_state();
        t_poll();
        t_enable();
        t_late_enable();
        t_update_gate();
        t_freeze();
        t_read_events();
        t_stat_write();
        t_reset_clear();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule